// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block collects level-sensitive device requests and per-processor software and directed requests, and turns them into one 4-bit interrupt priority level for each of up to four processors. Software talks to it through a simple word-addressed register bus. Each processor owns a small bank with a pending register and two write-only ports. One port raises pending bits and the other drops them. A system bank holds a readable view of the device request lines, a source mask, two write-only ports that clear or set mask bits, and a target register. The target register names the single processor that receives every system-wide device interrupt.

Device sources are grouped onto priority levels by a fixed table. The output level of a processor is the highest level found among its own pending requests and, when it is the current target, the enabled system sources. A global mask-all bit in the system mask blocks every device source at once. After reset all device sources are masked, so software must open them explicitly.

The register bus is a request/response stream. A request is accepted on every cycle in which `req_valid` is high, and the block never applies back-pressure. A read produces exactly one response with `rsp_valid` high on the following cycle, and the requester must be able to take it then. Writes produce no response.

Top module: `irq_router_mp`

## Requirements
- R1: After reset every processor pending register reads 0, the system mask reads 0xFFFFFFFF, the target reads 0, every `irq_level` field is 0 and `rsp_valid` is low.
- R2: Writing the set port of processor k (word address 4k+2) sets the pending bits written as 1. Bits written as 0 are unchanged, and bits 0 and 16 always read 0. The pending register is read at word address 4k.
- R3: Writing the clear port of processor k (word address 4k+1) clears the pending bits written as 1. Bits written as 0 are unchanged.
- R4: The mask reads at system word 1. Writing 1s to the mask-clear port (system word 2) clears those mask bits, which enables those sources. Writing 1s to the mask-set port (system word 3) sets those bits, which disables those sources. Bits written as 0 are unchanged. The system bank starts at word address 4*NCPU.
- R5: While mask bit 31 is 1, no device source contributes to any processor level.
- R6: The system pending register (system word 0) reads `dev_irq` bits 30..0 as they are at the read, with bit 31 reading 0.
- R7: Device source bits map to levels as follows. Bits 7/0 go to 2, 8/1 to 3, 18 to 4, 9/2 to 5, 16 to 6, 10/3 to 7, 20 to 8, 11/4/30 to 9, 19 to 10, 12/5/22 to 11, 14/15 to 12, and 17 to 13. All other bits reach no level.
- R8: The target register (system word 4) is readable and writable. Only the processor it names sees enabled device sources.
- R9: For each processor, `irq_level` equals the highest n (1..15) such that pending bit n or bit 16+n is set, or that a mapped enabled source is active for a target processor. When nothing qualifies it is 0. The level appears one cycle after the state that causes it.
- R10: A read request yields `rsp_valid` high in the next cycle with the addressed data. Write-only ports and unmapped addresses read 0, and no response follows a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| dev_irq | input | 32 | Level device request lines, synchronous to clk |
| irq_level | output | 4*NCPU | Priority level per processor, processor k in bits 4k+3..4k |

## Verification
The assertions assume that `dev_irq` and all request fields are synchronous to `clk` and stable around its rising edge, and that values written to the target register lie below NCPU. They also assume that `req_addr` holds a defined value whenever `req_valid` is high. The stimulus drives every input only on falling edges and writes only legal processor indices to the target. It holds the device lines steady across each level check, so each expected level follows from a single settled state.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DW     = 32;
  localparam int NLVL   = 16;
  localparam int LVL_W  = 4;
  localparam int HALF   = 16;
  localparam logic [DW-1:0] CPU_LEGAL = 32'hFFFE_FFFE;

  // priority level reached by a device source bit; 0 means none
  function automatic logic [LVL_W-1:0] src_level(input int b);
    case (b)
      0, 7:         return 4'd2;
      1, 8:         return 4'd3;
      18:           return 4'd4;
      2, 9:         return 4'd5;
      16:           return 4'd6;
      3, 10:        return 4'd7;
      20:           return 4'd8;
      4, 11, 30:    return 4'd9;
      19:           return 4'd10;
      5, 12, 22:    return 4'd11;
      14, 15:       return 4'd12;
      17:           return 4'd13;
      default:      return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
  import irq_route_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   pend,
  output logic [NLVL-1:0] lvl_vec
);
  logic [DW-1:0] wbits;
  assign wbits = wdata & CPU_LEGAL;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= '0;
    else if (set_we) pend <= pend | wbits;
    else if (clr_we) pend <= pend & ~wbits;
  end

  // hard level n at bit n, soft level n at bit 16+n
  assign lvl_vec = {pend[HALF+NLVL-1:HALF+1] | pend[NLVL-1:1], 1'b0};

  // R2: bits written as 0 to the set port keep their value
  a_r2_set_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((pend & ~$past(wdata)) == ($past(pend) & ~$past(wdata))));
  // R3: bits written as 0 to the clear port keep their value
  a_r3_clear_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((pend & ~$past(wdata)) == ($past(pend) & ~$past(wdata))));
  // R3: bits written as 1 to the clear port are gone
  a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((pend & $past(wdata)) == '0));
endmodule

// File: rtl/irq_sys_route.sv
module irq_sys_route
  import irq_route_pkg::*;
#(
  parameter int TW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   dev,
  input  logic            mclr_we,
  input  logic            mset_we,
  input  logic            tgt_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   mask,
  output logic [DW-1:0]   pend_view,
  output logic [TW-1:0]   target,
  output logic [NLVL-1:0] sys_vec
);
  logic [DW-1:0] eff;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '1;
    else if (mclr_we) mask <= mask & ~wdata;
    else if (mset_we) mask <= mask | wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      target <= '0;
    else if (tgt_we) target <= wdata[TW-1:0];
  end

  assign pend_view = {1'b0, dev[DW-2:0]};
  assign eff = mask[DW-1] ? '0 : (pend_view & ~mask);

  always_comb begin
    sys_vec = '0;
    for (int b = 0; b < DW; b++)
      if (eff[b]) sys_vec[src_level(b)] = 1'b1;
    sys_vec[0] = 1'b0;
  end

  // R4: a 1 written to the clear port enables that source
  a_r4_clear_enables: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_we |=> ((mask & $past(wdata)) == '0));
  // R4: a 1 written to the set port disables that source
  a_r4_set_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (mset_we && !mclr_we) |=> ((mask & $past(wdata)) == $past(wdata)));
  // R5: mask-all blocks every device source
  a_r5_maskall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mask[DW-1] |-> (sys_vec == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_route_pkg::*;
(
  input  logic [NLVL-1:0]  vec,
  output logic [LVL_W-1:0] lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 1; i < NLVL; i++)
      if (vec[i]) lvl = LVL_W'(i);
  end

  // R9: the level is the top set bit, or 0 with nothing set
  always_comb begin
    a_r9_is_highest: assert ((lvl == '0 && vec[NLVL-1:1] == '0) ||
                             (lvl != '0 && (vec >> lvl) == NLVL'(1)));
  end
endmodule

// File: rtl/irq_router_mp.sv
module irq_router_mp
  import irq_route_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int AW   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [DW-1:0]         req_wdata,
  output logic                  rsp_valid,
  output logic [DW-1:0]         rsp_rdata,
  input  logic [DW-1:0]         dev_irq,
  output logic [NCPU*LVL_W-1:0] irq_level
);
  localparam int TW       = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int OFF_W    = 2;
  localparam int SYS_BASE = NCPU << OFF_W;

  logic wr, rd, in_cpu;
  logic [AW-OFF_W-1:0] cpu_field;
  logic [OFF_W-1:0]    off;
  logic [AW-1:0]       sys_off;

  assign wr        = req_valid &&  req_write;
  assign rd        = req_valid && !req_write;
  assign in_cpu    = (int'(req_addr) < SYS_BASE);
  assign cpu_field = req_addr[AW-1:OFF_W];
  assign off       = req_addr[OFF_W-1:0];
  assign sys_off   = req_addr - AW'(SYS_BASE);

  logic mclr_we, mset_we, tgt_we;
  assign mclr_we = wr && !in_cpu && sys_off == AW'(2);
  assign mset_we = wr && !in_cpu && sys_off == AW'(3);
  assign tgt_we  = wr && !in_cpu && sys_off == AW'(4);

  logic [DW-1:0]   mask, pend_view;
  logic [TW-1:0]   target;
  logic [NLVL-1:0] sys_vec;

  irq_sys_route #(.TW(TW)) u_sys (
    .clk(clk), .rst_n(rst_n), .dev(dev_irq),
    .mclr_we(mclr_we), .mset_we(mset_we), .tgt_we(tgt_we),
    .wdata(req_wdata), .mask(mask), .pend_view(pend_view),
    .target(target), .sys_vec(sys_vec)
  );

  logic [DW-1:0]   pend     [NCPU];
  logic [NLVL-1:0] bank_vec [NCPU];
  logic [NLVL-1:0] cand     [NCPU];
  logic [LVL_W-1:0] lvl_d   [NCPU];

  for (genvar k = 0; k < NCPU; k++) begin : g_cpu
    logic hit;
    assign hit = wr && in_cpu && cpu_field == (AW-OFF_W)'(k);

    irq_cpu_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_we(hit && off == OFF_W'(2)),
      .clr_we(hit && off == OFF_W'(1)),
      .wdata(req_wdata), .pend(pend[k]), .lvl_vec(bank_vec[k])
    );

    assign cand[k] = bank_vec[k] | ((target == TW'(k)) ? sys_vec : '0);

    irq_prio_enc u_enc (.vec(cand[k]), .lvl(lvl_d[k]));

    always_ff @(posedge clk) begin
      if (!rst_n) irq_level[k*LVL_W +: LVL_W] <= '0;
      else        irq_level[k*LVL_W +: LVL_W] <= lvl_d[k];
    end

    // R9: nothing qualifying gives level 0 on the next cycle
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cand[k] == '0) |=> (irq_level[k*LVL_W +: LVL_W] == '0));
    // R8: a non-target processor with empty bank stays at level 0
    a_r8_nontarget_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (target != TW'(k) && bank_vec[k] == '0) |=> (irq_level[k*LVL_W +: LVL_W] == '0));
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_cpu) begin
      for (int k = 0; k < NCPU; k++)
        if (cpu_field == (AW-OFF_W)'(k) && off == '0) rd_mux = pend[k];
    end else begin
      case (sys_off)
        AW'(0):  rd_mux = pend_view;
        AW'(1):  rd_mux = mask;
        AW'(4):  rd_mux = DW'(target);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  // R10: each read gets a response next cycle, nothing else does
  a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
endmodule

// File: tb/tb_irq_router_mp.sv
module tb_irq_router_mp;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam int AW   = 6;
  localparam int SB   = NCPU * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, dev_irq = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NCPU*4-1:0] irq_level;

  irq_router_mp #(.NCPU(NCPU), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .dev_irq(dev_irq), .irq_level(irq_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int    q_kind[$];
  int    q_cpu[$];
  logic [31:0] q_exp[$];
  string q_tag[$];

  // monitor: compare every queued expectation at the falling edge
  initial forever begin
    @(negedge clk);
    while (q_kind.size() > 0) begin
      int k; int c; logic [31:0] e; string t; logic [31:0] act;
      k = q_kind.pop_front(); c = q_cpu.pop_front();
      e = q_exp.pop_front();  t = q_tag.pop_front();
      n_cmp++;
      if (k == 0) act = 32'(irq_level[c*4 +: 4]);
      else        act = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
      if (act !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  task automatic push(input int k, input int c, input logic [31:0] e, input string t);
    q_kind.push_back(k); q_cpu.push_back(c); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(a);
    @(posedge clk); #1;
    push(1, 0, e, t);
    @(negedge clk);
    req_valid = 0;
    #1;
  endtask

  task automatic lvl_chk(input int c, input int e, input string t);
    @(posedge clk); @(posedge clk); #1;
    push(0, c, 32'(e), t);
    @(negedge clk); #1;
  endtask

  task automatic set_dev(input logic [31:0] v);
    @(negedge clk);
    dev_irq = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    for (int c = 0; c < NCPU; c++) lvl_chk(c, 0, "R1 level after reset");
    rd_chk(SB+1, 32'hFFFF_FFFF, "R1 mask after reset");
    rd_chk(SB+4, 32'h0, "R1 target after reset");
    rd_chk(0, 32'h0, "R1 pending after reset");
    // R2 set port, hard 5 on cpu1
    wr(4+2, 32'h0000_0020);
    lvl_chk(1, 5, "R2 hard level 5 on cpu1");
    lvl_chk(0, 0, "R2 cpu0 untouched");
    wr(4+2, 32'h0200_0000);
    lvl_chk(1, 9, "R9 soft level 9 wins");
    wr(4+2, 32'h0001_0001);
    rd_chk(4, 32'h0200_0020, "R2 bits 0 and 16 ignored");
    // R3 clear port
    wr(4+1, 32'h0);
    rd_chk(4, 32'h0200_0020, "R3 zero clear no effect");
    wr(4+1, 32'h0200_0000);
    lvl_chk(1, 5, "R3 soft cleared");
    // R6 / R5 device with mask
    set_dev(32'h8008_0000);
    rd_chk(SB+0, 32'h0008_0000, "R6 system pending view");
    lvl_chk(0, 0, "R4 masked source silent");
    wr(SB+2, 32'h0008_0000);
    rd_chk(SB+1, 32'hFFF7_FFFF, "R4 mask clear port");
    lvl_chk(0, 0, "R5 mask-all blocks");
    wr(SB+2, 32'h8000_0000);
    lvl_chk(0, 10, "R7 timer to level 10");
    lvl_chk(1, 5, "R8 non-target cpu1");
    // R8 target move
    wr(SB+4, 32'd1);
    rd_chk(SB+4, 32'd1, "R8 target readback");
    lvl_chk(1, 10, "R8 cpu1 receives system");
    lvl_chk(0, 0, "R8 cpu0 loses system");
    wr(SB+4, 32'd0);
    // R7 mapping sweep
    wr(SB+2, 32'hFFFF_FFFF);
    set_dev(32'h0000_0080); lvl_chk(0, 2,  "R7 bit7 to 2");
    set_dev(32'h0000_0002); lvl_chk(0, 3,  "R7 bit1 to 3");
    set_dev(32'h4000_0000); lvl_chk(0, 9,  "R7 bit30 to 9");
    set_dev(32'h0040_0000); lvl_chk(0, 11, "R7 bit22 to 11");
    set_dev(32'h0000_4000); lvl_chk(0, 12, "R7 bit14 to 12");
    set_dev(32'h0001_0000); lvl_chk(0, 6,  "R7 bit16 to 6");
    set_dev(32'h1000_0000); lvl_chk(0, 0,  "R7 bit28 unmapped");
    set_dev(32'h0002_0000); lvl_chk(0, 13, "R7 bit17 to 13");
    wr(SB+3, 32'h0002_0000);
    lvl_chk(0, 0, "R4 set port disables");
    // R9 bank plus system: highest wins
    set_dev(32'h0008_0000);
    wr(0+2, 32'h0000_4000);
    lvl_chk(0, 14, "R9 hard 14 above timer");
    wr(0+1, 32'h0000_4000);
    lvl_chk(0, 10, "R9 falls back to timer");
    // R10 write-only and unmapped reads
    rd_chk(1, 32'h0, "R10 write-only port reads 0");
    rd_chk(SB+6, 32'h0, "R10 unmapped reads 0");
    @(negedge clk);
    lvl_chk(0, 10, "R10 no response after write");
    if (rsp_valid !== 1'b0) begin
      n_bad++; $display("FAIL R10 spurious response: actual %b expected 0", rsp_valid);
    end
    n_cmp++;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule